// File: doc/BRIEF.md
# Unipolar Frequency-Doubled SPWM Bridge Generator

This block drives the four switches of a single-phase full bridge. One triangular carrier, made by an up/down counter, is shared by both bridge legs. Each leg compares the carrier with its own duty value. Leg A takes its duty directly from a sine pulse-width table. Leg B takes the value mirrored about half the modulus, so the two legs follow sine references of opposite phase. The voltage across the bridge then switches at twice the carrier rate, which eases the output filter.

The table lives in a small internal RAM that the system loads through a write port. A wrapping pointer walks through the table, and both legs take a fresh duty pair at every carrier minimum. Each leg drives a complementary high/low pair, and a programmable dead time is inserted at every transition. A fault input blanks all four gates in the same cycle. While the fault is present, or while enable is low, the carrier is held at zero.

Top module: `spwm_bridge`

## Requirements
- R1: While running (enable high, fault low), the carrier counter steps 0, 1, …, modulus, modulus−1, …, 1 and then repeats, so one carrier period is 2×modulus clocks. While not running, the counter is held at 0 and counts up once it restarts.
- R2: In each cycle where the running counter is 0, both duty registers load from the table entry at the current pointer, and that new pair takes effect on the next clock. At all other times the duty registers keep their value.
- R3: The pointer advances by one at every reload. After entry tableLen−1 it returns to 0, so only entries 0 to tableLen−1 are ever used. When the block stops, the pointer resets to 0.
- R4: The raw leg A command is on when dutyA ≥ modulus or when carrier < dutyA, where dutyA is the table entry.
- R5: The leg B duty is modulus − entry, or 0 when the entry is ≥ modulus. The leg B raw command follows the rule of R4 with this duty.
- R6: The high and low gates of one leg are never on together.
- R7: Each gate pair follows its raw command one clock later. After every change of the raw command, both gates of that leg stay off for deadTime clocks.
- R8: A high fault input forces all four gates low in the same cycle, without waiting for a clock edge. It also stops the carrier. After the fault is released, operation resumes from counter 0 and pointer 0.
- R9: With enable low, all four gates are low.
- R10: An entry of 0 gives a leg A that is constantly low-side on and a leg B that is constantly high-side on. An entry equal to the modulus gives the reverse. Neither case produces any pulse.
- R11: A table write stores tblWrData at tblWrAddr on the clock edge where tblWrEn is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the carrier and the gates |
| fault | input | 1 | Blanks all gates at once and stops the carrier |
| tblWrEn | input | 1 | Table write strobe |
| tblWrAddr | input | 8 | Table write address |
| tblWrData | input | 15 | Pulse-width value to store |
| modulus | input | 15 | Carrier peak count (half period in clocks) |
| deadTime | input | 8 | Blanking time in clocks at each transition |
| tableLen | input | 8 | Number of table entries used before the pointer wraps |
| legAHi | output | 1 | Leg A high-side gate |
| legALo | output | 1 | Leg A low-side gate |
| legBHi | output | 1 | Leg B high-side gate |
| legBLo | output | 1 | Leg B low-side gate |

## Verification
A carrier that overshoots or turns at the wrong count changes the number of gate-on clocks in each period, so the per-period on-time counts differ within one carrier period. The same is true of a wrong mirror for leg B. A pointer that wraps at the wrong place feeds unused table entries into the duty registers, and the on-time totals over a few periods drift away from the two-entry pattern. A dead-time counter that reloads or decrements wrongly shows up as a wrong count of clocks in which both gates are off. A missing fault gate is visible within one clock, because the gates are sampled in the same cycle the fault rises.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
  typedef struct packed {
    logic run;     // carrier active
    logic reload;  // carrier at minimum: latch a new duty pair
  } ctrl_stb_t;
endpackage

// File: rtl/spwm_ctrl.sv
module spwm_ctrl
  import spwm_pkg::*;
#(
  parameter int CNT_W  = 15,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              fault,
  input  logic [CNT_W-1:0]  modulus,
  input  logic [ADDR_W-1:0] tableLen,
  output logic [CNT_W-1:0]  cnt,
  output logic [ADDR_W-1:0] ptr,
  output ctrl_stb_t         stb
);
  logic countUp;
  logic run;
  logic [CNT_W:0]  cntInc;
  logic [ADDR_W:0] ptrInc;

  assign run    = enable && !fault;
  assign cntInc = {1'b0, cnt} + 1'b1;
  assign ptrInc = {1'b0, ptr} + 1'b1;

  always_comb begin
    stb.run    = run;
    stb.reload = run && (cnt == '0);
  end

  // triangular carrier
  always_ff @(posedge clk) begin
    if (!rstN || !run) begin
      cnt     <= '0;
      countUp <= 1'b1;
    end else if (countUp) begin
      if (cntInc >= {1'b0, modulus}) begin
        cnt     <= modulus;
        countUp <= 1'b0;
      end else begin
        cnt <= cntInc[CNT_W-1:0];
      end
    end else begin
      if (cnt <= 1) begin
        cnt     <= '0;
        countUp <= 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  // sine table pointer
  always_ff @(posedge clk) begin
    if (!rstN || !run) begin
      ptr <= '0;
    end else if (stb.reload) begin
      if (ptrInc >= {1'b0, tableLen}) ptr <= '0;
      else                            ptr <= ptrInc[ADDR_W-1:0];
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(modulus) && $past(cnt <= modulus)) |-> (cnt <= modulus)); // R1
  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(tableLen) && tableLen != '0 && $past(ptr < tableLen)) |-> (ptr < tableLen)); // R3
  AST_STOP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    $past(!run) |-> (cnt == '0)); // R1
endmodule

// File: rtl/spwm_dpath.sv
module spwm_dpath
  import spwm_pkg::*;
#(
  parameter int CNT_W  = 15,
  parameter int ADDR_W = 8,
  parameter int DT_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_stb_t         stb,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [ADDR_W-1:0] ptr,
  input  logic [CNT_W-1:0]  modulus,
  input  logic [DT_W-1:0]   deadTime,
  input  logic              fault,
  input  logic              tblWrEn,
  input  logic [ADDR_W-1:0] tblWrAddr,
  input  logic [CNT_W-1:0]  tblWrData,
  output logic [1:0]        gateHi,
  output logic [1:0]        gateLo
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int LEGS  = 2;

  logic [CNT_W-1:0] pwTable [DEPTH];
  logic [CNT_W-1:0] entry;
  logic [CNT_W-1:0] mirror;
  logic [CNT_W-1:0] duty [LEGS];
  logic [LEGS-1:0]  raw;

  always_ff @(posedge clk) begin
    if (tblWrEn) pwTable[tblWrAddr] <= tblWrData;
  end

  assign entry  = pwTable[ptr];
  assign mirror = (entry >= modulus) ? '0 : (modulus - entry);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      duty[0] <= '0;
      duty[1] <= '0;
    end else if (stb.reload) begin
      duty[0] <= entry;
      duty[1] <= mirror;
    end
  end

  AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(stb.reload) |-> ($stable(duty[0]) && $stable(duty[1]))); // R2

  for (genvar i = 0; i < LEGS; i++) begin : g_leg
    logic            curRaw;
    logic [DT_W-1:0] dtCnt;

    assign raw[i] = (duty[i] >= modulus) || (cnt < duty[i]);

    always_ff @(posedge clk) begin
      if (!rstN || !stb.run) begin
        curRaw <= 1'b0;
        dtCnt  <= deadTime;
      end else if (raw[i] != curRaw) begin
        curRaw <= raw[i];
        dtCnt  <= deadTime;
      end else if (dtCnt != '0) begin
        dtCnt <= dtCnt - 1'b1;
      end
    end

    assign gateHi[i] = curRaw  && (dtCnt == '0) && stb.run && !fault;
    assign gateLo[i] = !curRaw && (dtCnt == '0) && stb.run && !fault;

    AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rstN)
      !(gateHi[i] && gateLo[i])); // R6
    AST_DEAD_GAP_HI: assert property (@(posedge clk) disable iff (!rstN)
      ($rose(gateHi[i]) && $stable(deadTime) && deadTime != '0) |-> $past(!gateLo[i])); // R7
    AST_DEAD_GAP_LO: assert property (@(posedge clk) disable iff (!rstN)
      ($rose(gateLo[i]) && $stable(deadTime) && deadTime != '0) |-> $past(!gateHi[i])); // R7
  end
endmodule

// File: rtl/spwm_bridge.sv
module spwm_bridge
  import spwm_pkg::*;
#(
  parameter int CNT_W  = 15,
  parameter int ADDR_W = 8,
  parameter int DT_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              fault,
  input  logic              tblWrEn,
  input  logic [ADDR_W-1:0] tblWrAddr,
  input  logic [CNT_W-1:0]  tblWrData,
  input  logic [CNT_W-1:0]  modulus,
  input  logic [DT_W-1:0]   deadTime,
  input  logic [ADDR_W-1:0] tableLen,
  output logic              legAHi,
  output logic              legALo,
  output logic              legBHi,
  output logic              legBLo
);
  ctrl_stb_t         stb;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] ptr;
  logic [1:0]        gateHi;
  logic [1:0]        gateLo;

  spwm_ctrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .fault(fault),
    .modulus(modulus), .tableLen(tableLen),
    .cnt(cnt), .ptr(ptr), .stb(stb)
  );

  spwm_dpath #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DT_W(DT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .cnt(cnt), .ptr(ptr),
    .modulus(modulus), .deadTime(deadTime), .fault(fault),
    .tblWrEn(tblWrEn), .tblWrAddr(tblWrAddr), .tblWrData(tblWrData),
    .gateHi(gateHi), .gateLo(gateLo)
  );

  assign legAHi = gateHi[0];
  assign legALo = gateLo[0];
  assign legBHi = gateHi[1];
  assign legBLo = gateLo[1];

  AST_FAULT_OFF: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> !(legAHi || legALo || legBHi || legBLo)); // R8
  AST_IDLE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !(legAHi || legALo || legBHi || legBLo)); // R9
endmodule

// File: tb/sim_spwm_bridge.sv
module sim_spwm_bridge;
  localparam int CLK_P = 10;
  localparam int WIN   = 400;   // ten periods at modulus 20

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic fault = 1'b0;
  logic tblWrEn = 1'b0;
  logic [7:0]  tblWrAddr = '0;
  logic [14:0] tblWrData = '0;
  logic [14:0] modulus = 15'd20;
  logic [7:0]  deadTime = '0;
  logic [7:0]  tableLen = 8'd1;
  logic legAHi, legALo, legBHi, legBLo;

  int nChecks = 0;
  int nFails  = 0;
  int hiA, loA, hiB, loB, offA, riseA, shoot;

  always #(CLK_P/2) clk = ~clk;

  spwm_bridge u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .fault(fault),
    .tblWrEn(tblWrEn), .tblWrAddr(tblWrAddr), .tblWrData(tblWrData),
    .modulus(modulus), .deadTime(deadTime), .tableLen(tableLen),
    .legAHi(legAHi), .legALo(legALo), .legBHi(legBHi), .legBLo(legBLo)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wrTable(input int addr, input int val);
    @(negedge clk);
    tblWrEn = 1'b1; tblWrAddr = addr[7:0]; tblWrData = val[14:0];
    @(negedge clk);
    tblWrEn = 1'b0;
  endtask

  task automatic measure(input int n);
    logic prevHi;
    hiA = 0; loA = 0; hiB = 0; loB = 0; offA = 0; riseA = 0; shoot = 0;
    prevHi = legAHi;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      hiA += int'(legAHi); loA += int'(legALo);
      hiB += int'(legBHi); loB += int'(legBLo);
      if (!legAHi && !legALo) offA++;
      if (legAHi && !prevHi) riseA++;
      if ((legAHi && legALo) || (legBHi && legBLo)) shoot++;
      prevHi = legAHi;
    end
  endtask

  task automatic restart(input int settle);
    @(negedge clk); enable = 1'b0;
    @(negedge clk); enable = 1'b1;
    repeat (settle) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R9 reset gates", int'({legAHi, legALo, legBHi, legBLo}), 0);
  endtask

  task automatic t_duty;
    for (int a = 0; a < 4; a++) wrTable(a, 5);
    tableLen = 8'd4; deadTime = 8'd0;
    restart(120);
    measure(WIN);
    chk("R4 leg A high clocks", hiA, 90);
    chk("R4 leg A low clocks", loA, 310);
    chk("R5 leg B mirrored high clocks", hiB, 290);
    chk("R1 carrier periods", riseA, 10);
    chk("R6 shoot-through", shoot, 0);
  endtask

  task automatic t_dead;
    deadTime = 8'd3;
    restart(120);
    measure(WIN);
    chk("R7 leg A high with dead time", hiA, 60);
    chk("R7 leg A both-off clocks", offA, 60);
    chk("R7 leg B high with dead time", hiB, 260);
    chk("R6 shoot-through dead", shoot, 0);
    deadTime = 8'd0;
  endtask

  task automatic t_extremes;
    @(negedge clk); enable = 1'b0;
    for (int a = 0; a < 4; a++) wrTable(a, 0);
    restart(120);
    measure(WIN);
    chk("R10 zero entry A high", hiA, 0);
    chk("R10 zero entry A low", loA, WIN);
    chk("R10 zero entry B high", hiB, WIN);
    @(negedge clk); enable = 1'b0;
    for (int a = 0; a < 4; a++) wrTable(a, 20);
    restart(120);
    measure(WIN);
    chk("R10 full entry A high", hiA, WIN);
    chk("R10 full entry B low", loB, WIN);
    chk("R10 full entry B high", hiB, 0);
  endtask

  task automatic t_wrap;
    @(negedge clk); enable = 1'b0;
    wrTable(0, 4); wrTable(1, 10); wrTable(2, 0); wrTable(3, 0);
    tableLen = 8'd2;
    restart(160);
    measure(WIN);
    chk("R3 wrap leg A high", hiA, 130);
    chk("R3 wrap leg B high", hiB, 250);
    chk("R11 written entries in use", loA, WIN - 130);
  endtask

  task automatic t_fault;
    @(negedge clk); enable = 1'b0;
    for (int a = 0; a < 2; a++) wrTable(a, 5);
    restart(130);
    #(CLK_P/4) fault = 1'b1;
    #1;
    chk("R8 same-cycle blank", int'({legAHi, legALo, legBHi, legBLo}), 0);
    measure(30);
    chk("R8 blanked while fault", hiA + loA + hiB + loB, 0);
    @(negedge clk); fault = 1'b0;
    repeat (120) @(negedge clk);
    measure(WIN);
    chk("R8 resume leg A high", hiA, 90);
    chk("R8 resume leg B high", hiB, 290);
  endtask

  task automatic t_enable;
    @(negedge clk); enable = 1'b0;
    measure(40);
    chk("R9 disabled gates", hiA + loA + hiB + loB, 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    nFails++; nChecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk); rstN = 1'b1;
    t_duty();
    t_dead();
    t_extremes();
    t_wrap();
    t_fault();
    t_enable();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule